// File: doc/BRIEF.md
# Exception Control Register Set

This block keeps the processor state that an exception handler needs. When the core raises an exception strobe, the block records several things at once. It saves a return address, adjusted when the faulting instruction sits in a branch delay slot. It records a 5-bit exception code and a delay-slot flag in the cause register. For address faults it also saves the offending data address. Taking an exception turns off the global interrupt enable, and a return-from-exception pulse turns it back on.

Six hardware interrupt lines are registered into pending bits of the cause register, alongside two software-settable pending bits. A status register holds a per-level mask and the global enable. The interrupt request to the core is raised only when the enable is set and at least one pending bit is also unmasked.

Software reaches the registers through a plain register-number read/write port, used by the move-to and move-from coprocessor instructions. This port is a control path, so it has no valid/ready handshake. A write takes effect at the next clock edge, and reads are combinational from the stored state.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 all read 0 and `irq_req` is low.
- R2: On an exception outside a delay slot, register 14 (return address) takes `exc_pc`, cause bits 6:2 take `exc_code`, and cause bit 31 becomes 0.
- R3: On an exception with `exc_in_delay` high, register 14 takes `exc_pc` minus 4, and cause bit 31 becomes 1.
- R4: Exception codes 4 (load/fetch address fault) and 5 (store address fault) load `exc_badaddr` into register 8. Every other code leaves register 8 unchanged.
- R5: An exception clears status bit 0 (global enable). An `eret` pulse sets it. When both occur in the same cycle, the exception wins.
- R6: Cause bits 15:10 show `hw_irq[5:0]` as sampled at the previous clock edge and cannot be written. Cause bits 9:8 are software pending bits, written from the write data.
- R7: A write to register 13 loads bits 31 and 6:2 from the write data, so writing 0 clears the code and the delay flag.
- R8: Status bits 15:8 (mask) and bit 0 (enable) are writable, and all other status bits read 0. `irq_req` is high exactly when the enable is 1 and some cause bit 15:8 is set together with the matching mask bit.
- R9: Reads of any register number other than 8, 12, 13 or 14 return 0. Writes to those numbers and writes to register 8 have no effect.
- R10: When an exception and a software write to register 13 or 14 fall in the same cycle, the exception capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_badaddr | input | 32 | Faulting data address |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| hw_irq | input | 6 | Hardware interrupt lines |
| eret | input | 1 | Return from exception, re-enables interrupts |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is an exception landing in the same cycle as a software write to the return-address register, together with an `eret` pulse. That cycle decides both capture priority and enable priority. The bench drives all three strobes in one cycle and then reads back the return address and the status word. The interrupt request path is also exercised by walking the mask and the enable around a pending bit that is held by a hardware line and cannot be written.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;
  localparam int RNUM_W = 5;

  localparam logic [RNUM_W-1:0] RN_BADADDR = 5'd8;
  localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [RNUM_W-1:0] RN_EPC     = 5'd14;

  localparam logic [CODE_W-1:0] EC_IRQ     = 5'd0;
  localparam logic [CODE_W-1:0] EC_ADDR_LD = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADDR_ST = 5'd5;
  localparam logic [CODE_W-1:0] EC_BUS_IF  = 5'd6;

  // bit positions shared by cause and status layouts
  localparam int CODE_LO = 2;
  localparam int PEND_LO = 8;
  localparam int PEND_W  = 8;
  localparam int BD_BIT  = 31;

  function automatic logic is_addr_fault(input logic [CODE_W-1:0] c);
    return (c == EC_ADDR_LD) || (c == EC_ADDR_ST);
  endfunction
endpackage

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_badaddr,
  input  logic              exc_in_delay,
  input  logic              wr_cause,
  input  logic              wr_epc,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   bad_q,
  output logic [CODE_W-1:0] code_q,
  output logic              bd_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q  <= '0;
      bad_q  <= '0;
      code_q <= '0;
      bd_q   <= 1'b0;
    end else if (exc_valid) begin
      epc_q  <= exc_in_delay ? (exc_pc - STEP) : exc_pc;
      bd_q   <= exc_in_delay;
      code_q <= exc_code;
      if (is_addr_fault(exc_code)) bad_q <= exc_badaddr;
    end else begin
      if (wr_epc) epc_q <= wdata;
      if (wr_cause) begin
        code_q <= wdata[CODE_LO +: CODE_W];
        bd_q   <= wdata[BD_BIT];
      end
    end
  end
endmodule

// File: rtl/exc_pend.sv
module exc_pend
  import exc_pkg::*;
#(
  parameter int N_HW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              wr_sw,
  input  logic [PEND_W-N_HW-1:0] sw_wdata,
  output logic [PEND_W-1:0] pend_q
);
  localparam int N_SW = PEND_W - N_HW;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q[N_SW-1:0] <= '0;
    else if (wr_sw) pend_q[N_SW-1:0] <= sw_wdata;
  end

  for (genvar g = 0; g < N_HW; g++) begin : g_hw
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[N_SW+g] <= 1'b0;
      else        pend_q[N_SW+g] <= hw_irq[g];
    end
  end
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic              eret,
  input  logic              wr,
  input  logic              wdata_ie,
  input  logic [PEND_W-1:0] wdata_mask,
  input  logic [PEND_W-1:0] pend,
  output logic              ie_q,
  output logic [PEND_W-1:0] mask_q,
  output logic              irq_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr) mask_q <= wdata_mask;
      if (exc_valid)  ie_q <= 1'b0;
      else if (eret)  ie_q <= 1'b1;
      else if (wr)    ie_q <= wdata_ie;
    end
  end

  assign irq_req = ie_q && |(pend & mask_q);
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int N_HW       = 6,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_badaddr,
  input  logic              exc_in_delay,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              eret,
  input  logic              reg_we,
  input  logic [RNUM_W-1:0] reg_addr,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  output logic              irq_req
);
  localparam int N_SW = PEND_W - N_HW;

  logic              wr_cause, wr_epc, wr_status;
  logic [XLEN-1:0]   epc_q, bad_q;
  logic [CODE_W-1:0] code_q;
  logic              bd_q, ie_q;
  logic [PEND_W-1:0] pend_q, mask_q;
  logic [XLEN-1:0]   cause_w, status_w;

  assign wr_cause  = reg_we && (reg_addr == RN_CAUSE);
  assign wr_epc    = reg_we && (reg_addr == RN_EPC);
  assign wr_status = reg_we && (reg_addr == RN_STATUS);

  exc_capture #(.INSN_BYTES(INSN_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_badaddr(exc_badaddr), .exc_in_delay(exc_in_delay),
    .wr_cause(wr_cause), .wr_epc(wr_epc), .wdata(reg_wdata),
    .epc_q(epc_q), .bad_q(bad_q), .code_q(code_q), .bd_q(bd_q)
  );

  exc_pend #(.N_HW(N_HW)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .wr_sw(wr_cause),
    .sw_wdata(reg_wdata[PEND_LO +: N_SW]), .pend_q(pend_q)
  );

  exc_status u_stat (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .eret(eret),
    .wr(wr_status), .wdata_ie(reg_wdata[0]),
    .wdata_mask(reg_wdata[PEND_LO +: PEND_W]), .pend(pend_q),
    .ie_q(ie_q), .mask_q(mask_q), .irq_req(irq_req)
  );

  always_comb begin
    cause_w = '0;
    cause_w[BD_BIT] = bd_q;
    cause_w[PEND_LO +: PEND_W] = pend_q;
    cause_w[CODE_LO +: CODE_W] = code_q;
    status_w = '0;
    status_w[PEND_LO +: PEND_W] = mask_q;
    status_w[0] = ie_q;
  end

  always_comb begin
    unique case (reg_addr)
      RN_BADADDR: reg_rdata = bad_q;
      RN_STATUS:  reg_rdata = status_w;
      RN_CAUSE:   reg_rdata = cause_w;
      RN_EPC:     reg_rdata = epc_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk #(
  parameter int N_HW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_valid,
  input logic [4:0]      exc_code,
  input logic [31:0]     exc_pc,
  input logic            exc_in_delay,
  input logic [N_HW-1:0] hw_irq,
  input logic            irq_req,
  input logic [31:0]     epc,
  input logic [31:0]     bad,
  input logic            bd,
  input logic            ie,
  input logic [N_HW-1:0] hw_pend
);
  a_r2_epc_plain: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_in_delay |=> epc == $past(exc_pc) && !bd);

  a_r3_epc_delay: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_in_delay |=> epc == $past(exc_pc) - 32'd4 && bd);

  a_r4_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && (exc_code == 5'd4 || exc_code == 5'd5)) |=> $stable(bad));

  a_r5_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !ie);

  a_r6_hw_sample: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hw_pend == $past(hw_irq));

  a_r8_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq_req);
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.N_HW(N_HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
  .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .hw_irq(hw_irq),
  .irq_req(irq_req), .epc(epc_q), .bad(bad_q), .bd(bd_q), .ie(ie_q),
  .hw_pend(pend_q[N_SW +: N_HW])
);

// File: tb/tb_exc_ctrl_regs.sv
module tb_exc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid, exc_in_delay, eret, reg_we;
  logic [4:0]  exc_code, reg_addr;
  logic [31:0] exc_pc, exc_badaddr, reg_wdata, reg_rdata;
  logic [5:0]  hw_irq;
  logic        irq_req;
  int nvec = 0, nfail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  exc_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_badaddr(exc_badaddr), .exc_in_delay(exc_in_delay),
    .hw_irq(hw_irq), .eret(eret), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic take(input logic [4:0] c, input logic [31:0] pc,
                      input logic [31:0] ba, input logic dly);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = c; exc_pc = pc; exc_badaddr = ba; exc_in_delay = dly;
    @(negedge clk);
    exc_valid = 1'b0; exc_in_delay = 1'b0;
  endtask

  task automatic t_reset;
    rd(5'd8, v);  chk("R1 badaddr", v, 0);
    rd(5'd12, v); chk("R1 status", v, 0);
    rd(5'd13, v); chk("R1 cause", v, 0);
    rd(5'd14, v); chk("R1 epc", v, 0);
    chk("R1 irq_req", {31'b0, irq_req}, 0);
  endtask

  task automatic t_plain;
    wr(5'd12, 32'h1);
    take(5'd6, 32'h0000_0400, 32'h0000_DEAD, 1'b0);
    rd(5'd14, v); chk("R2 epc", v, 32'h400);
    rd(5'd13, v); chk("R2 cause", v, 32'd6 << 2);
    rd(5'd8, v);  chk("R4 bad unchanged code6", v, 0);
    rd(5'd12, v); chk("R5 ie cleared", v, 0);
  endtask

  task automatic t_delay;
    take(5'd12, 32'h0000_0100, 32'h0, 1'b1);
    rd(5'd14, v); chk("R3 epc", v, 32'h0FC);
    rd(5'd13, v); chk("R3 cause", v, 32'h8000_0000 | (32'd12 << 2));
  endtask

  task automatic t_addr;
    take(5'd4, 32'h10, 32'h0000_1003, 1'b0);
    rd(5'd8, v); chk("R4 load fault", v, 32'h1003);
    take(5'd5, 32'h14, 32'h0000_2002, 1'b0);
    rd(5'd8, v); chk("R4 store fault", v, 32'h2002);
    take(5'd0, 32'h18, 32'h0000_0055, 1'b0);
    rd(5'd8, v); chk("R4 irq code keeps", v, 32'h2002);
  endtask

  task automatic t_eret;
    @(negedge clk); eret = 1'b1;
    @(negedge clk); eret = 1'b0;
    rd(5'd12, v); chk("R5 eret sets ie", v, 32'h1);
    wr(5'd12, 32'hFFFF_FF01);
    rd(5'd12, v); chk("R8 status fields", v, 32'h0000_FF01);
    wr(5'd12, 32'h0);
  endtask

  task automatic t_cause_wr;
    wr(5'd13, 32'h0);
    rd(5'd13, v); chk("R7 cause clear", v, 0);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R6 R7 cause write", v, 32'h8000_037C);
    wr(5'd13, 32'h0);
  endtask

  task automatic t_irq;
    @(negedge clk); hw_irq = 6'b000001;
    @(negedge clk);
    rd(5'd13, v); chk("R6 hw pending", v, 32'h0000_0400);
    wr(5'd13, 32'h0);
    rd(5'd13, v); chk("R6 hw not writable", v, 32'h0000_0400);
    wr(5'd12, 32'h0000_0801);
    chk("R8 masked off", {31'b0, irq_req}, 0);
    wr(5'd12, 32'h0000_0401);
    chk("R8 unmasked", {31'b0, irq_req}, 1);
    wr(5'd12, 32'h0000_0400);
    chk("R8 enable off", {31'b0, irq_req}, 0);
    @(negedge clk); hw_irq = 6'b0;
    @(negedge clk);
    wr(5'd13, 32'h0000_0100);
    wr(5'd12, 32'h0000_0101);
    chk("R6 R8 sw pending irq", {31'b0, irq_req}, 1);
    wr(5'd13, 32'h0);
    chk("R8 sw cleared", {31'b0, irq_req}, 0);
    wr(5'd12, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(5'd3, 32'hAAAA_5555);
    rd(5'd3, v); chk("R9 unmapped read", v, 0);
    wr(5'd8, 32'h1234);
    rd(5'd8, v); chk("R9 badaddr not writable", v, 32'h2002);
  endtask

  task automatic t_collide;
    wr(5'd12, 32'h1);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd6; exc_pc = 32'h0000_0800; exc_in_delay = 1'b0;
    eret = 1'b1; reg_we = 1'b1; reg_addr = 5'd14; reg_wdata = 32'h0000_9999;
    @(negedge clk);
    exc_valid = 1'b0; eret = 1'b0; reg_we = 1'b0;
    rd(5'd14, v); chk("R10 exc beats epc write", v, 32'h800);
    rd(5'd12, v); chk("R5 exc beats eret", v, 0);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd5; exc_pc = 32'h0000_0900; exc_badaddr = 32'h77;
    reg_we = 1'b1; reg_addr = 5'd13; reg_wdata = 32'h0;
    @(negedge clk);
    exc_valid = 1'b0; reg_we = 1'b0;
    rd(5'd13, v); chk("R10 exc beats cause write", v, 32'd5 << 2);
  endtask

  initial begin
    rst_n = 1'b0; exc_valid = 1'b0; exc_in_delay = 1'b0; eret = 1'b0; reg_we = 1'b0;
    exc_code = '0; reg_addr = '0; exc_pc = '0; exc_badaddr = '0; reg_wdata = '0;
    hw_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_delay;
    t_addr;
    t_eret;
    t_cause_wr;
    t_irq;
    t_unmapped;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #800000;
    nvec++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule